// File: doc/BRIEF.md
# Per-Pin Four-Way Peripheral Multiplexer

This block is the register bank and pad router for one I/O port of up to 32 pins. For every pin it decides who drives the pad: the GPIO output and direction registers, or one of four on-chip peripheral functions (A, B, C, D). It also holds each pin's pull-up, pull-down and input-hysteresis-off settings and reports the live pad level back to software.

Software reaches the block over a plain single-cycle register bus. A write is taken at the rising clock edge when `bus_wen` is high. A read is combinational from `bus_addr`. Most per-pin state sits behind a set/clear/status triplet. A 1 bit in a set or clear word acts on that pin, and a 0 bit leaves it alone. The two function-select words and the hysteresis word are plain read/write registers, and software changes them by read-modify-write. Pad outputs are combinational from the registers, so they follow a write one clock edge later. Every control pin here is plain level signalling. No data stream crosses the block's edge, so it has no valid/ready handshake and no back-pressure.

Top module: `pinmux_port_ctrl`

## Requirements
- R1: After reset, every pin is GPIO-owned (ownership status 0x008 reads all ones). Direction, data, pull-down, write-mask, both select words and hysteresis-off all read 0. Pull-up status 0x068 reads all ones.
- R2: Ownership uses 0x000 (1 bits give pins back to GPIO), 0x004 (1 bits hand pins to a peripheral) and 0x008 (status, 1 = GPIO-owned). 0 bits in a write leave pins unchanged.
- R3: The function code of pin n is {bit n of 0x074, bit n of 0x070}. Codes 0, 1, 2 and 3 select A, B, C and D. A peripheral-owned pin takes `pad_out` and `pad_oe` from `periph_do`/`periph_oe` at the selected function index.
- R4: A GPIO-owned pin takes `pad_out` from the data register and `pad_oe` from the direction register, whatever the peripherals drive. Direction uses set 0x010, clear 0x014 and status 0x018.
- R5: The select words at 0x070 and 0x074 are plain read/write and read back the last value written.
- R6: Pull-up uses clear 0x060, set 0x064 and status 0x068, and the status drives `pad_pu`.
- R7: Pull-down uses clear 0x090, set 0x094 and status 0x098, and the status drives `pad_pd`. It is independent of the pull-up.
- R8: The word at 0x100 is plain read/write, and a 1 in bit n drives `pad_st_off[n]` (hysteresis off).
- R9: The write mask uses set 0x0A0, clear 0x0A4 and status 0x0A8. A write to 0x038 changes only the data bits whose mask bit is 1. Data set 0x030 and clear 0x034 ignore the mask.
- R10: Status words (0x008, 0x018, 0x068, 0x098, 0x0A8) are read-only. A write to them changes nothing.
- R11: Reading 0x03C returns `pad_in`. Reading an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wen | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Combinational read data |
| periph_do | input | NFUNC x NPINS | Output value from each peripheral function |
| periph_oe | input | NFUNC x NPINS | Output enable from each peripheral function |
| pad_in | input | NPINS | Live pad levels |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_pd | output | NPINS | Pad pull-down enable |
| pad_st_off | output | NPINS | Pad hysteresis disable |

## Verification
The hardest case to reach is one where four neighbouring pins are all peripheral-owned at once and each carries a different function code. Only then does a wrong bit order in the 2-bit code, or a wrong function index, show up. The bench builds that state through the ownership and select writes. It then drives each peripheral with a one-hot pattern, followed by the complementary pattern, so that only the correctly chosen function can yield the expected pad word. The masked direct data write is reached by narrowing the mask between two writes, so that bits outside the mask are seen to hold.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NFUNC = 4;
  localparam int OFF_W = 12;

  localparam logic [OFF_W-1:0] A_OWN_GPIO = 12'h000;
  localparam logic [OFF_W-1:0] A_OWN_PER  = 12'h004;
  localparam logic [OFF_W-1:0] A_OWN_ST   = 12'h008;
  localparam logic [OFF_W-1:0] A_DIR_SET  = 12'h010;
  localparam logic [OFF_W-1:0] A_DIR_CLR  = 12'h014;
  localparam logic [OFF_W-1:0] A_DIR_ST   = 12'h018;
  localparam logic [OFF_W-1:0] A_DAT_SET  = 12'h030;
  localparam logic [OFF_W-1:0] A_DAT_CLR  = 12'h034;
  localparam logic [OFF_W-1:0] A_DAT_VAL  = 12'h038;
  localparam logic [OFF_W-1:0] A_PAD_LVL  = 12'h03C;
  localparam logic [OFF_W-1:0] A_PU_CLR   = 12'h060;
  localparam logic [OFF_W-1:0] A_PU_SET   = 12'h064;
  localparam logic [OFF_W-1:0] A_PU_ST    = 12'h068;
  localparam logic [OFF_W-1:0] A_SEL_LO   = 12'h070;
  localparam logic [OFF_W-1:0] A_SEL_HI   = 12'h074;
  localparam logic [OFF_W-1:0] A_PD_CLR   = 12'h090;
  localparam logic [OFF_W-1:0] A_PD_SET   = 12'h094;
  localparam logic [OFF_W-1:0] A_PD_ST    = 12'h098;
  localparam logic [OFF_W-1:0] A_WM_SET   = 12'h0A0;
  localparam logic [OFF_W-1:0] A_WM_CLR   = 12'h0A4;
  localparam logic [OFF_W-1:0] A_WM_ST    = 12'h0A8;
  localparam logic [OFF_W-1:0] A_HYST_OFF = 12'h100;

  typedef enum logic [1:0] {
    FN_A = 2'd0,
    FN_B = 2'd1,
    FN_C = 2'd2,
    FN_D = 2'd3
  } func_code_e;
endpackage

// File: rtl/pinmux_bit_reg.sv
module pinmux_bit_reg #(
  parameter int         W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] ld_mask_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = (q_o & ~clr_i) | set_i;
    if (ld_i) nxt = (nxt & ~ld_mask_i) | (ld_val_i & ld_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RST;
    else        q_o <= nxt;
  end
endmodule

// File: rtl/pinmux_pad_route.sv
module pinmux_pad_route
  import pinmux_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]            gpio_own,
  input  logic [NPINS-1:0]            sel_lo,
  input  logic [NPINS-1:0]            sel_hi,
  input  logic [NPINS-1:0]            gpio_do,
  input  logic [NPINS-1:0]            gpio_oe,
  input  logic [NFUNC-1:0][NPINS-1:0] periph_do,
  input  logic [NFUNC-1:0][NPINS-1:0] periph_oe,
  output logic [NPINS-1:0]            pad_out,
  output logic [NPINS-1:0]            pad_oe
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    func_code_e code;
    logic       fn_do, fn_oe;
    assign code  = func_code_e'({sel_hi[n], sel_lo[n]});
    assign fn_do = periph_do[code][n];
    assign fn_oe = periph_oe[code][n];
    assign pad_out[n] = gpio_own[n] ? gpio_do[n] : fn_do;
    assign pad_oe[n]  = gpio_own[n] ? gpio_oe[n] : fn_oe;
  end
endmodule

// File: rtl/pinmux_readback.sv
module pinmux_readback
  import pinmux_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  own_q,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  dat_q,
  input  logic [NPINS-1:0]  pad_in,
  input  logic [NPINS-1:0]  pu_q,
  input  logic [NPINS-1:0]  pd_q,
  input  logic [NPINS-1:0]  sel_lo_q,
  input  logic [NPINS-1:0]  sel_hi_q,
  input  logic [NPINS-1:0]  wm_q,
  input  logic [NPINS-1:0]  hyst_q,
  output logic [NPINS-1:0]  rdata
);
  always_comb begin
    unique case (addr)
      ADDR_W'(A_OWN_ST):   rdata = own_q;
      ADDR_W'(A_DIR_ST):   rdata = dir_q;
      ADDR_W'(A_DAT_VAL):  rdata = dat_q;
      ADDR_W'(A_PAD_LVL):  rdata = pad_in;
      ADDR_W'(A_PU_ST):    rdata = pu_q;
      ADDR_W'(A_PD_ST):    rdata = pd_q;
      ADDR_W'(A_SEL_LO):   rdata = sel_lo_q;
      ADDR_W'(A_SEL_HI):   rdata = sel_hi_q;
      ADDR_W'(A_WM_ST):    rdata = wm_q;
      ADDR_W'(A_HYST_OFF): rdata = hyst_q;
      default:             rdata = '0;
    endcase
  end
endmodule

// File: rtl/pinmux_port_ctrl.sv
module pinmux_port_ctrl
  import pinmux_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wen,
  input  logic [NPINS-1:0]            bus_wdata,
  output logic [NPINS-1:0]            bus_rdata,
  input  logic [NFUNC-1:0][NPINS-1:0] periph_do,
  input  logic [NFUNC-1:0][NPINS-1:0] periph_oe,
  input  logic [NPINS-1:0]            pad_in,
  output logic [NPINS-1:0]            pad_out,
  output logic [NPINS-1:0]            pad_oe,
  output logic [NPINS-1:0]            pad_pu,
  output logic [NPINS-1:0]            pad_pd,
  output logic [NPINS-1:0]            pad_st_off
);
  localparam logic [NPINS-1:0] ONES  = '1;
  localparam logic [NPINS-1:0] ZEROS = '0;

  logic [NPINS-1:0] own_q, dir_q, dat_q, pu_q, pd_q, wm_q;
  logic [NPINS-1:0] sel_lo_q, sel_hi_q, hyst_q;

  function automatic logic hit(input logic [OFF_W-1:0] off);
    return bus_wen && (bus_addr == ADDR_W'(off));
  endfunction

  function automatic logic [NPINS-1:0] wbits(input logic [OFF_W-1:0] off);
    return hit(off) ? bus_wdata : ZEROS;
  endfunction

  // ownership: 1 = GPIO-owned
  pinmux_bit_reg #(.W(NPINS), .RST(ONES)) u_own (
    .clk(clk), .rst_n(rst_n), .set_i(wbits(A_OWN_GPIO)), .clr_i(wbits(A_OWN_PER)),
    .ld_i(1'b0), .ld_val_i(ZEROS), .ld_mask_i(ZEROS), .q_o(own_q));

  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_i(wbits(A_DIR_SET)), .clr_i(wbits(A_DIR_CLR)),
    .ld_i(1'b0), .ld_val_i(ZEROS), .ld_mask_i(ZEROS), .q_o(dir_q));

  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_wm (
    .clk(clk), .rst_n(rst_n), .set_i(wbits(A_WM_SET)), .clr_i(wbits(A_WM_CLR)),
    .ld_i(1'b0), .ld_val_i(ZEROS), .ld_mask_i(ZEROS), .q_o(wm_q));

  // data: set/clear ignore the mask, direct write is gated by it
  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_dat (
    .clk(clk), .rst_n(rst_n), .set_i(wbits(A_DAT_SET)), .clr_i(wbits(A_DAT_CLR)),
    .ld_i(hit(A_DAT_VAL)), .ld_val_i(bus_wdata), .ld_mask_i(wm_q), .q_o(dat_q));

  pinmux_bit_reg #(.W(NPINS), .RST(ONES)) u_pu (
    .clk(clk), .rst_n(rst_n), .set_i(wbits(A_PU_SET)), .clr_i(wbits(A_PU_CLR)),
    .ld_i(1'b0), .ld_val_i(ZEROS), .ld_mask_i(ZEROS), .q_o(pu_q));

  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_pd (
    .clk(clk), .rst_n(rst_n), .set_i(wbits(A_PD_SET)), .clr_i(wbits(A_PD_CLR)),
    .ld_i(1'b0), .ld_val_i(ZEROS), .ld_mask_i(ZEROS), .q_o(pd_q));

  // plain read/write words
  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_sel_lo (
    .clk(clk), .rst_n(rst_n), .set_i(ZEROS), .clr_i(ZEROS),
    .ld_i(hit(A_SEL_LO)), .ld_val_i(bus_wdata), .ld_mask_i(ONES), .q_o(sel_lo_q));

  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_sel_hi (
    .clk(clk), .rst_n(rst_n), .set_i(ZEROS), .clr_i(ZEROS),
    .ld_i(hit(A_SEL_HI)), .ld_val_i(bus_wdata), .ld_mask_i(ONES), .q_o(sel_hi_q));

  pinmux_bit_reg #(.W(NPINS), .RST(ZEROS)) u_hyst (
    .clk(clk), .rst_n(rst_n), .set_i(ZEROS), .clr_i(ZEROS),
    .ld_i(hit(A_HYST_OFF)), .ld_val_i(bus_wdata), .ld_mask_i(ONES), .q_o(hyst_q));

  pinmux_pad_route #(.NPINS(NPINS)) u_route (
    .gpio_own(own_q), .sel_lo(sel_lo_q), .sel_hi(sel_hi_q),
    .gpio_do(dat_q), .gpio_oe(dir_q),
    .periph_do(periph_do), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe));

  pinmux_readback #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_rd (
    .addr(bus_addr), .own_q(own_q), .dir_q(dir_q), .dat_q(dat_q), .pad_in(pad_in),
    .pu_q(pu_q), .pd_q(pd_q), .sel_lo_q(sel_lo_q), .sel_hi_q(sel_hi_q),
    .wm_q(wm_q), .hyst_q(hyst_q), .rdata(bus_rdata));

  assign pad_pu     = pu_q;
  assign pad_pd     = pd_q;
  assign pad_st_off = hyst_q;
endmodule

// File: rtl/pinmux_port_ctrl_chk.sv
module pinmux_port_ctrl_chk
  import pinmux_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  own_q,
  input logic [NPINS-1:0]  dat_q,
  input logic [NPINS-1:0]  wm_q,
  input logic [NPINS-1:0]  sel_lo_q,
  input logic [NPINS-1:0]  pad_pu
);
  logic wr_own_gpio, wr_own_st, wr_dat, wr_sel_lo, wr_pu_clr;
  assign wr_own_gpio = bus_wen && bus_addr == ADDR_W'(A_OWN_GPIO);
  assign wr_own_st   = bus_wen && bus_addr == ADDR_W'(A_OWN_ST);
  assign wr_dat      = bus_wen && bus_addr == ADDR_W'(A_DAT_VAL);
  assign wr_sel_lo   = bus_wen && bus_addr == ADDR_W'(A_SEL_LO);
  assign wr_pu_clr   = bus_wen && bus_addr == ADDR_W'(A_PU_CLR);

  a_r2_give_back_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
    wr_own_gpio |=> own_q == ($past(own_q) | $past(bus_wdata)));

  a_r10_status_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_own_st |=> $stable(own_q));

  a_r5_select_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel_lo |=> sel_lo_q == $past(bus_wdata));

  a_r9_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> ((dat_q ^ $past(dat_q)) & ~$past(wm_q)) == '0);

  a_r6_pullup_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pu_clr |=> (pad_pu & $past(bus_wdata)) == '0);
endmodule

bind pinmux_port_ctrl pinmux_port_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .bus_wdata(bus_wdata), .own_q(own_q), .dat_q(dat_q), .wm_q(wm_q),
  .sel_lo_q(sel_lo_q), .pad_pu(pad_pu));

// File: tb/test_pinmux_port_ctrl.sv
module test_pinmux_port_ctrl;
  import pinmux_pkg::*;
  localparam int NPINS = 32;
  localparam int AW    = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wen = 1'b0;
  logic [NPINS-1:0] bus_wdata = '0, bus_rdata;
  logic [NFUNC-1:0][NPINS-1:0] periph_do = '0, periph_oe = '0;
  logic [NPINS-1:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd, pad_st_off;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinmux_port_ctrl #(.NPINS(NPINS), .ADDR_W(AW)) i_pinmux_port_ctrl (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic [11:0] wa;
    logic [31:0] wd;
    logic [11:0] ra;
    logic [31:0] ex;
  } vec_t;

  // walked in order; each row writes once then reads one word
  localparam vec_t TBL [17] = '{
    '{8'd2,  12'h004, 32'h0000_000F, 12'h008, 32'hFFFF_FFF0}, // R2 hand off
    '{8'd2,  12'h004, 32'h0000_0000, 12'h008, 32'hFFFF_FFF0}, // R2 zero write
    '{8'd2,  12'h000, 32'h0000_0003, 12'h008, 32'hFFFF_FFF3}, // R2 give back
    '{8'd5,  12'h070, 32'hA5A5_0000, 12'h070, 32'hA5A5_0000}, // R5
    '{8'd5,  12'h074, 32'h0F0F_1234, 12'h074, 32'h0F0F_1234}, // R5
    '{8'd10, 12'h008, 32'h0000_0000, 12'h008, 32'hFFFF_FFF3}, // R10
    '{8'd6,  12'h060, 32'h0000_00FF, 12'h068, 32'hFFFF_FF00}, // R6
    '{8'd7,  12'h094, 32'h0000_000F, 12'h098, 32'h0000_000F}, // R7
    '{8'd7,  12'h090, 32'h0000_0003, 12'h098, 32'h0000_000C}, // R7
    '{8'd8,  12'h100, 32'h8000_0001, 12'h100, 32'h8000_0001}, // R8
    '{8'd9,  12'h0A0, 32'h0000_00F0, 12'h0A8, 32'h0000_00F0}, // R9
    '{8'd9,  12'h038, 32'hFFFF_FFFF, 12'h038, 32'h0000_00F0}, // R9
    '{8'd9,  12'h0A4, 32'h0000_0030, 12'h0A8, 32'h0000_00C0}, // R9
    '{8'd9,  12'h038, 32'h0000_0000, 12'h038, 32'h0000_0030}, // R9
    '{8'd9,  12'h030, 32'h0000_0001, 12'h038, 32'h0000_0031}, // R9 set ignores mask
    '{8'd9,  12'h034, 32'h0000_0010, 12'h038, 32'h0000_0021}, // R9 clear ignores mask
    '{8'd4,  12'h010, 32'h0000_0005, 12'h018, 32'h0000_0005}  // R4 direction
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic reset_checks(input string tag);
    logic [31:0] v;
    rd(12'h008, v); check({tag, " R1 own"}, v, 32'hFFFF_FFFF);
    rd(12'h068, v); check({tag, " R1 pullup"}, v, 32'hFFFF_FFFF);
    rd(12'h098, v); check({tag, " R1 pulldown"}, v, 32'h0);
    rd(12'h070, v); check({tag, " R1 sel"}, v, 32'h0);
    rd(12'h038, v); check({tag, " R1 data"}, v, 32'h0);
    check({tag, " R1 pad_oe"}, pad_oe, 32'h0);
    check({tag, " R1 pad_st_off"}, pad_st_off, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_checks("reset");

    foreach (TBL[i]) begin
      wr(TBL[i].wa, TBL[i].wd);
      rd(TBL[i].ra, v);
      check($sformatf("R%0d row %0d", TBL[i].req, i), v, TBL[i].ex);
    end

    // R3: pins 4..7 peripheral-owned with codes A,B,C,D
    wr(12'h004, 32'h0000_00F0);
    wr(12'h070, 32'h0000_00A0);
    wr(12'h074, 32'h0000_00C0);
    periph_do[0] = 32'h10; periph_do[1] = 32'h20; periph_do[2] = 32'h40; periph_do[3] = 32'h80;
    periph_oe[0] = 32'h10; periph_oe[1] = 32'h20; periph_oe[2] = 32'h40; periph_oe[3] = 32'h80;
    #1;
    check("R3 one-hot out", {28'h0, pad_out[7:4]}, 32'hF);
    check("R3 one-hot oe", {28'h0, pad_oe[7:4]}, 32'hF);
    for (int k = 0; k < NFUNC; k++) begin
      periph_do[k] = ~periph_do[k];
      periph_oe[k] = ~periph_oe[k];
    end
    #1;
    check("R3 complement out", {28'h0, pad_out[7:4]}, 32'h0);
    check("R3 complement oe", {28'h0, pad_oe[7:4]}, 32'h0);
    // R4: pins 0,1 GPIO-owned: data bits 01, direction bits 01
    check("R4 gpio out", {30'h0, pad_out[1:0]}, 32'h1);
    check("R4 gpio oe", {30'h0, pad_oe[1:0]}, 32'h1);
    // pins 2,3 peripheral-owned, code 0 (A) drives ~0x10 -> ones
    check("R3 code A pins 2-3", {30'h0, pad_out[3:2]}, 32'h3);
    // R6 R7 R8 pad pins
    check("R6 pad_pu", pad_pu, 32'hFFFF_FF00);
    check("R7 pad_pd", pad_pd, 32'h0000_000C);
    check("R8 pad_st_off", pad_st_off, 32'h8000_0001);
    // R11
    pad_in = 32'h1234_5678;
    rd(12'h03C, v); check("R11 pad level", v, 32'h1234_5678);
    rd(12'h02C, v); check("R11 unmapped", v, 32'h0);
    // R10: write to direction status is ignored
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, v); check("R10 dir status", v, 32'h0000_0005);

    // mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    reset_checks("rereset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule